// File: doc/BRIEF.md
# Board Interrupt and Status Register File

This block is the register side of a board-level companion logic device. Sixteen external interrupt lines are gathered into a sticky pending register, filtered by an enable register, and a single registered interrupt line is sent to the host processor. Software reads the pending register, clears it by overwriting it, and reprograms the enable register through a plain synchronous 32-bit register bus. The bus has a byte address, a write strobe, write data and combinational read data.

The block also holds eight general storage words for LEDs, switches and miscellaneous control. It has two card-socket words whose low five bits are writable. Each socket word has a fixed ready flag and an active-low card-present flag. That flag tracks one dedicated interrupt line: line 9 for socket 0 and line 13 for socket 1.

The host interrupt comes from a two-state machine. In IRQ_IDLE the line is low. The transition *raise* moves it to IRQ_RAISED when the next enable and pending values share a set bit. In IRQ_RAISED the line is high. The transition *drop* returns it to IRQ_IDLE when they no longer share one.

Top module: `brd_irq_regfile`

## Requirements
- R1: The eight storage words at byte offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88 and 0x90 are full 32-bit read/write words. A write is visible on a read in the next cycle.
- R2: A read of any offset not listed in R1, R5 or R8 returns zero. A write to such an offset changes no register.
- R3: When an interrupt line is high at a clock edge and its enable bit is set, the pending bit at the same position becomes 1. It stays 1 after the line falls, until software overwrites it.
- R4: A high interrupt line whose enable bit is clear leaves its pending bit unchanged.
- R5: A write to the enable word (0xC0) or the pending word (0xD0) stores the written value ANDed with 0x000FEEFF. Bits outside that pattern always read as zero.
- R6: After every clock edge, host_irq equals the OR of all bits of (pending AND enable) as they stand after that edge.
- R7: When a write to the enable or pending word and a high line meet in one cycle, the written value is applied first. Each line that is high and enabled under the newly applied enable value is then ORed into pending.
- R8: Socket 0 (0xE4 is socket 1, 0xE0 is socket 0) holds bit 5 = NOT line 9, and socket 1 holds bit 5 = NOT line 13. Each is updated at every clock edge.
- R9: A write to a socket word changes only bits 4:0. Bit 10 always reads 1, and bits 31:11, 9:6 always read 0.
- R10: After reset, both socket words read 0x00000420. Every other register reads zero, and host_irq is low.
- R11: Writing the pending word replaces it entirely, so writing zero clears all pending bits that no enabled high line re-sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_lines | input | 16 | External interrupt lines, active high |
| host_irq | output | 1 | Registered interrupt to the host |

## Verification
Each interrupt line is first driven with its enable clear and then with it set. This separates the "disabled lines are ignored" rule from the latching rule, and the unwritable enable bits 8 and 12 show up as lines that can never latch. A single pulse followed by idle cycles tells a sticky pending bit from one that tracks the line. Writes that coincide with high lines separate "write then merge" from "merge then overwrite". A full sweep of all 256 byte offsets, before and after writes of all-ones to unmapped offsets, separates the decoded words from aliases. A long pseudo-random mix of writes, reads and line patterns checks host_irq every cycle against a model kept in the bench.

// File: rtl/brd_irq_pkg.sv
package brd_irq_pkg;

    localparam int REG_W    = 32;
    localparam int BUS_AW   = 8;
    localparam int N_LINES  = 16;
    localparam int N_GP     = 8;

    localparam logic [REG_W-1:0] IRQ_WMASK = 32'h000F_EEFF;

    localparam logic [BUS_AW-1:0] OFF_ENABLE = 8'hC0;
    localparam logic [BUS_AW-1:0] OFF_PEND   = 8'hD0;
    localparam logic [BUS_AW-1:0] OFF_SOCK0  = 8'hE0;
    localparam logic [BUS_AW-1:0] OFF_SOCK1  = 8'hE4;

    localparam int SOCK_RW_W   = 5;
    localparam int SOCK_CD_BIT = 5;
    localparam int SOCK_RDY_BIT = 10;
    localparam int CD_LINE0    = 9;
    localparam int CD_LINE1    = 13;

    typedef enum logic [0:0] {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    function automatic logic [BUS_AW-1:0] gp_offset(input int idx);
        logic [BUS_AW-1:0] off;
        case (idx)
            0:       off = 8'h10;
            1:       off = 8'h14;
            2:       off = 8'h40;
            3:       off = 8'h60;
            4:       off = 8'h80;
            5:       off = 8'h84;
            6:       off = 8'h88;
            default: off = 8'h90;
        endcase
        return off;
    endfunction

endpackage

// File: rtl/brd_gp_bank.sv
module brd_gp_bank
    import brd_irq_pkg::*;
#(
    parameter int N_WORDS = N_GP,
    parameter int DW      = REG_W,
    parameter int AW      = BUS_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          hit
);

    logic [N_WORDS-1:0] sel;
    logic [DW-1:0]      word_q [N_WORDS];

    for (genvar g = 0; g < N_WORDS; g++) begin : g_word
        assign sel[g] = (addr == AW'(gp_offset(g)));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[g] <= '0;
            end else if (wr && sel[g]) begin
                word_q[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_WORDS; i++) begin
            if (sel[i]) rdata = rdata | word_q[i];
        end
    end

    assign hit = |sel;

endmodule

// File: rtl/brd_sock_reg.sv
module brd_sock_reg
    import brd_irq_pkg::*;
#(
    parameter int DW      = REG_W,
    parameter int RW_W    = SOCK_RW_W,
    parameter int CD_BIT  = SOCK_CD_BIT,
    parameter int RDY_BIT = SOCK_RDY_BIT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [RW_W-1:0] wdata,
    input  logic            card_line,
    output logic [DW-1:0]   value
);

    logic [RW_W-1:0] ctl_q;
    logic            cd_n_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            cd_n_q <= 1'b1;
        end else begin
            cd_n_q <= ~card_line;
            if (wr) ctl_q <= wdata;
        end
    end

    always_comb begin
        value             = '0;
        value[RW_W-1:0]   = ctl_q;
        value[CD_BIT]     = cd_n_q;
        value[RDY_BIT]    = 1'b1;
    end

endmodule

// File: rtl/brd_irq_core.sv
module brd_irq_core
    import brd_irq_pkg::*;
#(
    parameter int               DW     = REG_W,
    parameter int               NL     = N_LINES,
    parameter logic [DW-1:0]    WMASK  = IRQ_WMASK
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_wr,
    input  logic          pend_wr,
    input  logic [DW-1:0] wdata,
    input  logic [NL-1:0] lines,
    output logic [DW-1:0] en_q,
    output logic [DW-1:0] pend_q,
    output logic          irq_out
);

    logic [DW-1:0] lines_ext;
    logic [DW-1:0] en_nxt;
    logic [DW-1:0] pend_nxt;
    logic          fire;
    irq_state_e    state_q;
    irq_state_e    state_nxt;

    assign lines_ext = DW'(lines);

    // Software value first, then enabled lines merged on top.
    always_comb begin
        en_nxt   = en_wr   ? (wdata & WMASK) : en_q;
        pend_nxt = (pend_wr ? (wdata & WMASK) : pend_q) | (lines_ext & en_nxt);
        fire     = |(pend_nxt & en_nxt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            pend_q <= '0;
        end else begin
            en_q   <= en_nxt;
            pend_q <= pend_nxt;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_nxt;
    end

    // Transitions: raise and drop.
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (fire)  state_nxt = IRQ_RAISED;
            IRQ_RAISED: if (!fire) state_nxt = IRQ_IDLE;
        endcase
    end

    // Output process.
    always_comb begin
        irq_out = (state_q == IRQ_RAISED);
    end

endmodule

// File: rtl/brd_irq_regfile.sv
module brd_irq_regfile
    import brd_irq_pkg::*;
#(
    parameter int            DW    = REG_W,
    parameter int            AW    = BUS_AW,
    parameter int            NL    = N_LINES,
    parameter logic [DW-1:0] WMASK = IRQ_WMASK
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [NL-1:0] irq_lines,
    output logic          host_irq
);

    logic          sel_en;
    logic          sel_pend;
    logic          sel_s0;
    logic          sel_s1;
    logic [DW-1:0] gp_rdata;
    logic          gp_hit;
    logic [DW-1:0] en_q;
    logic [DW-1:0] pend_q;
    logic [DW-1:0] sock0_val;
    logic [DW-1:0] sock1_val;

    assign sel_en   = (bus_addr == AW'(OFF_ENABLE));
    assign sel_pend = (bus_addr == AW'(OFF_PEND));
    assign sel_s0   = (bus_addr == AW'(OFF_SOCK0));
    assign sel_s1   = (bus_addr == AW'(OFF_SOCK1));

    brd_gp_bank #(
        .N_WORDS (N_GP),
        .DW      (DW),
        .AW      (AW)
    ) u_gp (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (gp_rdata),
        .hit   (gp_hit)
    );

    brd_irq_core #(
        .DW    (DW),
        .NL    (NL),
        .WMASK (WMASK)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_wr   (bus_wr && sel_en),
        .pend_wr (bus_wr && sel_pend),
        .wdata   (bus_wdata),
        .lines   (irq_lines),
        .en_q    (en_q),
        .pend_q  (pend_q),
        .irq_out (host_irq)
    );

    brd_sock_reg #(
        .DW      (DW),
        .RW_W    (SOCK_RW_W),
        .CD_BIT  (SOCK_CD_BIT),
        .RDY_BIT (SOCK_RDY_BIT)
    ) u_sock0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr && sel_s0),
        .wdata     (bus_wdata[SOCK_RW_W-1:0]),
        .card_line (irq_lines[CD_LINE0]),
        .value     (sock0_val)
    );

    brd_sock_reg #(
        .DW      (DW),
        .RW_W    (SOCK_RW_W),
        .CD_BIT  (SOCK_CD_BIT),
        .RDY_BIT (SOCK_RDY_BIT)
    ) u_sock1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr && sel_s1),
        .wdata     (bus_wdata[SOCK_RW_W-1:0]),
        .card_line (irq_lines[CD_LINE1]),
        .value     (sock1_val)
    );

    always_comb begin
        bus_rdata = '0;
        if (gp_hit)        bus_rdata = gp_rdata;
        else if (sel_en)   bus_rdata = en_q;
        else if (sel_pend) bus_rdata = pend_q;
        else if (sel_s0)   bus_rdata = sock0_val;
        else if (sel_s1)   bus_rdata = sock1_val;
    end

endmodule

// File: rtl/brd_irq_chk.sv
module brd_irq_chk
    import brd_irq_pkg::*;
#(
    parameter int            DW    = REG_W,
    parameter int            AW    = BUS_AW,
    parameter int            NL    = N_LINES,
    parameter logic [DW-1:0] WMASK = IRQ_WMASK
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_wr,
    input logic [DW-1:0] bus_rdata,
    input logic [NL-1:0] irq_lines,
    input logic          host_irq,
    input logic [DW-1:0] en_q,
    input logic [DW-1:0] pend_q,
    input logic [DW-1:0] sock0_val,
    input logic [DW-1:0] sock1_val
);

    logic [DW-1:0] lines_ext;
    logic          mapped;
    logic          wr_en_word;
    logic          wr_pend_word;

    assign lines_ext    = DW'(irq_lines);
    assign wr_en_word   = bus_wr && (bus_addr == AW'(OFF_ENABLE));
    assign wr_pend_word = bus_wr && (bus_addr == AW'(OFF_PEND));

    always_comb begin
        mapped = (bus_addr == AW'(OFF_ENABLE)) || (bus_addr == AW'(OFF_PEND)) ||
                 (bus_addr == AW'(OFF_SOCK0))  || (bus_addr == AW'(OFF_SOCK1));
        for (int i = 0; i < N_GP; i++) begin
            if (bus_addr == AW'(gp_offset(i))) mapped = 1'b1;
        end
    end

    // R6
    irq_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq == (|(pend_q & en_q)));

    // R5
    pend_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & ~WMASK) == '0);

    // R5
    en_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q & ~WMASK) == '0);

    // R3
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pend_word |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    // R3
    latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_word |=> ((pend_q & $past(lines_ext & en_q)) == $past(lines_ext & en_q)));

    // R4
    disabled_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_word && !wr_pend_word) |=> ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0));

    // R8
    cd0_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sock0_val[SOCK_CD_BIT] == !$past(irq_lines[CD_LINE0])));

    // R8
    cd1_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sock1_val[SOCK_CD_BIT] == !$past(irq_lines[CD_LINE1])));

    // R9
    sock_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sock0_val[SOCK_RDY_BIT] && sock1_val[SOCK_RDY_BIT] &&
        (sock0_val[DW-1:SOCK_RDY_BIT+1] == '0) && (sock1_val[DW-1:SOCK_RDY_BIT+1] == '0) &&
        (sock0_val[SOCK_RDY_BIT-1:SOCK_CD_BIT+1] == '0) &&
        (sock1_val[SOCK_RDY_BIT-1:SOCK_CD_BIT+1] == '0));

    // R2
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (bus_rdata == '0));

endmodule

bind brd_irq_regfile brd_irq_chk #(
    .DW    (DW),
    .AW    (AW),
    .NL    (NL),
    .WMASK (WMASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .irq_lines (irq_lines),
    .host_irq  (host_irq),
    .en_q      (en_q),
    .pend_q    (pend_q),
    .sock0_val (sock0_val),
    .sock1_val (sock1_val)
);

// File: tb/sim_brd_irq_regfile.sv
module sim_brd_irq_regfile;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] MASK = 32'h000F_EEFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_lines = '0;
    logic        host_irq;

    int vectors = 0;
    int miscompares = 0;

    // bench model
    logic [31:0] m_gp [8];
    logic [31:0] m_en, m_pend;
    logic [4:0]  m_ctl0, m_ctl1;
    logic        m_cd0, m_cd1;
    logic        m_irq;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #(CLK_PERIOD/2) clk = ~clk;

    brd_irq_regfile u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_lines (irq_lines),
        .host_irq  (host_irq)
    );

    function automatic int gp_idx(input logic [7:0] a);
        case (a)
            8'h10: return 0;
            8'h14: return 1;
            8'h40: return 2;
            8'h60: return 3;
            8'h80: return 4;
            8'h84: return 5;
            8'h88: return 6;
            8'h90: return 7;
            default: return -1;
        endcase
    endfunction

    function automatic logic [7:0] pick_addr(input int k);
        case (k % 12)
            0: return 8'h10;  1: return 8'h14;  2: return 8'h40;  3: return 8'h60;
            4: return 8'h80;  5: return 8'h84;  6: return 8'h88;  7: return 8'h90;
            8: return 8'hC0;  9: return 8'hD0;  10: return 8'hE0; default: return 8'hE4;
        endcase
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        int g;
        g = gp_idx(a);
        if (g >= 0) return m_gp[g];
        case (a)
            8'hC0: return m_en;
            8'hD0: return m_pend;
            8'hE0: return 32'h400 | (32'(m_cd0) << 5) | 32'(m_ctl0);
            8'hE4: return 32'h400 | (32'(m_cd1) << 5) | 32'(m_ctl1);
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_gp[i] = '0;
        m_en = '0; m_pend = '0; m_ctl0 = '0; m_ctl1 = '0;
        m_cd0 = 1'b1; m_cd1 = 1'b1; m_irq = 1'b0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, check read before edge, update model, check irq after edge.
    task automatic cycle(input logic wr, input logic [7:0] a, input logic [31:0] d,
                         input logic [15:0] lines, input string req);
        logic [31:0] en_n, pend_n;
        int g;
        bus_wr = wr; bus_addr = a; bus_wdata = d; irq_lines = lines;
        #1;
        if (!wr) chk(req, bus_rdata, model_read(a));
        @(posedge clk);
        en_n   = (wr && a == 8'hC0) ? (d & MASK) : m_en;
        pend_n = ((wr && a == 8'hD0) ? (d & MASK) : m_pend) | ({16'h0, lines} & en_n);
        m_en = en_n; m_pend = pend_n;
        g = gp_idx(a);
        if (wr && g >= 0) m_gp[g] = d;
        if (wr && a == 8'hE0) m_ctl0 = d[4:0];
        if (wr && a == 8'hE4) m_ctl1 = d[4:0];
        m_cd0 = ~lines[9];
        m_cd1 = ~lines[13];
        m_irq = |(m_pend & m_en);
        @(negedge clk);
        chk("R6", {31'h0, host_irq}, {31'h0, m_irq});
    endtask

    task automatic rd(input logic [7:0] a, input logic [15:0] lines, input string req);
        cycle(1'b0, a, 32'h0, lines, req);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [15:0] lines,
                      input string req);
        cycle(1'b1, a, d, lines, req);
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : stimulus
        model_reset();
        repeat (3) @(negedge clk);
        #1;
        chk("R10", {31'h0, host_irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state, R2 unmapped reads zero
        for (int a = 0; a < 256; a += 4)
            rd(8'(a), 16'h0, (gp_idx(8'(a)) >= 0 || a >= 8'hC0) ? "R10" : "R2");

        // R1 walking ones and zeros through every storage word
        for (int k = 0; k < 8; k++) begin
            for (int b = 0; b < 32; b++) begin
                wr(pick_addr(k), 32'h1 << b, 16'h0, "R1");
                rd(pick_addr(k), 16'h0, "R1");
                wr(pick_addr(k), ~(32'h1 << b), 16'h0, "R1");
                rd(pick_addr(k), 16'h0, "R1");
            end
            wr(pick_addr(k), 32'hA5C3_0F00 ^ (32'(k) * 32'h0101_1111), 16'h0, "R1");
        end

        // R2 writes to every unmapped byte offset, then full readback
        for (int a = 0; a < 256; a++) begin
            if (gp_idx(8'(a)) < 0 && a != 8'hC0 && a != 8'hD0 && a != 8'hE0 && a != 8'hE4)
                wr(8'(a), 32'hFFFF_FFFF, 16'h0, "R2");
        end
        for (int a = 0; a < 256; a++) rd(8'(a), 16'h0, "R2");

        // R5 mask pattern on enable and pending
        wr(8'hC0, 32'hFFFF_FFFF, 16'h0, "R5");
        rd(8'hC0, 16'h0, "R5");
        wr(8'hD0, 32'hFFFF_FFFF, 16'h0, "R5");
        rd(8'hD0, 16'h0, "R5");
        // R11 overwrite clears
        wr(8'hD0, 32'h0, 16'h0, "R11");
        rd(8'hD0, 16'h0, "R11");
        wr(8'hD0, 32'h0005_0203, 16'h0, "R11");
        rd(8'hD0, 16'h0, "R11");

        // R3 / R4 per-line sweep
        for (int i = 0; i < 16; i++) begin
            wr(8'hC0, 32'h0, 16'h0, "R4");
            wr(8'hD0, 32'h0, 16'h0, "R11");
            rd(8'hD0, 16'h1 << i, "R4");
            rd(8'hD0, 16'h1 << i, "R4");
            rd(8'hD0, 16'h0, "R4");
            wr(8'hC0, 32'h1 << i, 16'h0, "R3");
            rd(8'hD0, 16'h1 << i, "R3");
            rd(8'hD0, 16'h0, "R3");
            rd(8'hD0, 16'h0, "R3");
            wr(8'hD0, 32'h0, 16'h0, "R11");
            rd(8'hD0, 16'h0, "R11");
        end

        // R7 write meets enabled high line in the same cycle
        wr(8'hC0, 32'h0000_00F0, 16'h0, "R7");
        wr(8'hD0, 32'h0001_0001, 16'h0020, "R7");
        rd(8'hD0, 16'h0, "R7");
        wr(8'hD0, 32'h0, 16'h0040, "R7");
        rd(8'hD0, 16'h0, "R7");
        wr(8'hD0, 32'h0, 16'h0, "R7");
        wr(8'hC0, 32'h0000_0002, 16'h0002, "R7");
        rd(8'hD0, 16'h0, "R7");
        wr(8'hC0, 32'h0, 16'h0004, "R7");
        rd(8'hD0, 16'h0, "R7");
        wr(8'hD0, 32'h0, 16'h0, "R11");

        // R8 card-detect follows lines 9 and 13
        for (int v = 0; v < 4; v++) begin
            rd(8'hE0, {2'b00, v[1], 3'b000, v[0], 9'h0}, "R8");
            rd(8'hE0, {2'b00, v[1], 3'b000, v[0], 9'h0}, "R8");
            rd(8'hE4, {2'b00, v[1], 3'b000, v[0], 9'h0}, "R8");
        end

        // R9 only low five bits writable
        wr(8'hE0, 32'hFFFF_FFFF, 16'h0, "R9");
        rd(8'hE0, 16'h0, "R9");
        wr(8'hE4, 32'hFFFF_FFEA, 16'h2000, "R9");
        rd(8'hE4, 16'h2000, "R9");
        wr(8'hE0, 32'h0000_0000, 16'h0, "R9");
        rd(8'hE0, 16'h0, "R9");

        // mixed pseudo-random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r, d;
            step_lfsr(); r = lfsr;
            step_lfsr(); d = lfsr;
            case (r[2:0])
                3'd0: wr(8'hC0, d, r[31:16] & r[23:8], "R3");
                3'd1: wr(8'hD0, d & {d[15:0], d[31:16]}, r[31:16] & r[23:8], "R7");
                3'd2: wr(r[3] ? 8'hE4 : 8'hE0, d, r[31:16], "R9");
                3'd3: wr(pick_addr(int'(r[7:4])), d, r[31:16] & r[23:8], "R1");
                default: rd(pick_addr(int'(r[7:4])), r[31:16] & r[23:8], "R3");
            endcase
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule